// File: doc/BRIEF.md
# Boot ROM Overlay Address Decoder

This block decodes every memory and I/O cycle of an 8-bit processor with a 16-bit address bus. Each cycle goes to one of three places: onboard RAM, a 4 KB ROM, or nothing. The ROM has two 2 KB halves. The boot half holds bootstrap and diagnostic code. The monitor half is mapped at the top of memory at all times.

Software controls where the boot half appears. It does so through an 8-bit addressable control latch, and each write to one I/O control port changes a single latch bit. After reset the latch is all zero, which selects the start-up map. In that map the boot half shows at address zero, so the processor fetches its first instructions from ROM. The same half also shows in its own window at 0xE800. Software can then return low memory to RAM and later remove the overlay completely.

A parameter selects 32 KB or 64 KB of RAM. Any cycle that reaches nothing mapped raises a flag, and the bus then reads as 0x00.

Top module: `boot_overlay_decoder`

## Requirements
- R1: While rst_ni is low, every control latch bit is 0 and the block shows the start-up map. A memory read of 0x0000 asserts rom_sel_o with rom_addr_o = 0x000.
- R2: Only an I/O write to port 0xFF changes the latch, and it changes exactly one bit. Data bits [2:0] hold the inverted index of that bit and data bit 3 holds the inverted value to store, so 0x04 sets bit 3 and 0x02 sets bit 5. The new map applies from the rising clock edge on which the write strobe is sampled.
- R3: When latch bit 3 is 1, the overlay is off. No address below 0xF000 decodes as ROM, whatever bit 5 holds. Such addresses go to RAM if RAM covers them and are unmapped otherwise.
- R4: When bit 3 = 0 and bit 5 = 0, memory reads of 0x0000–0x07FF and of 0xE800–0xEFFF select the ROM. rom_addr_o[11] = 0 and rom_addr_o[10:0] = addr[10:0].
- R5: When bit 3 = 0 and bit 5 = 1, only 0xE800–0xEFFF selects the ROM, and 0x0000–0x07FF goes to RAM.
- R6: Memory reads of 0xF800–0xFFFF always select the ROM with rom_addr_o[11] = 1 and rom_addr_o[10:0] = addr[10:0], whatever the latch holds.
- R7: With RAM_64K = 1, RAM covers every address that is not decoded as ROM. With RAM_64K = 0, RAM covers only 0x0000–0x7FFF.
- R8: zero_rd_o is 1 for a memory read that reaches neither RAM nor ROM. It is also 1 for an I/O read outside ports 0xF0–0xF7, including port 0xFF. It is 0 for every other cycle.
- R9: A memory write to an address decoded as ROM asserts none of ram_sel_o, ram_we_o and rom_sel_o. ram_sel_o and rom_sel_o are never 1 together.
- R10: An I/O cycle never asserts ram_sel_o, ram_we_o or rom_sel_o. A memory write to RAM asserts ram_sel_o and ram_we_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Processor address; the low 8 bits carry the I/O port number |
| io_i | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| data_i | input | 4 | Low data bus bits, used by control port writes |
| ram_sel_o | output | 1 | RAM access |
| ram_we_o | output | 1 | RAM write enable |
| rom_sel_o | output | 1 | ROM read |
| rom_addr_o | output | 12 | ROM address; bit 11 = 1 selects the monitor half |
| zero_rd_o | output | 1 | Read of unmapped space; the bus reads 0x00 |

## Verification
A wrong latch bit shows up on the very next memory read of 0x0000 or 0xE800: the cycle selects RAM where the ROM should answer, or the reverse. A latch write that lands on the wrong bit is caught the same way. The bench drives each control port encoding and then probes both overlay windows and the monitor range on the cycle after the write edge. A fault that changes a bit other than 3 or 5 cannot be seen at the ports, so the bench writes such bits and confirms that the map stays the same.

// File: rtl/boot_dec_pkg.sv
package boot_dec_pkg;
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_RAM  = 2'd1,
    REG_ROM  = 2'd2
  } region_e;
endpackage

// File: rtl/ctrl_latch.sv
module ctrl_latch #(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             val_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         q_o[b] <= 1'b0;
      else if (we_i && idx_i == IDX_W'(b)) q_o[b] <= val_i;
    end
  end
endmodule

// File: rtl/io_decode.sv
module io_decode #(
  parameter int CTRL_PORT = 8'hFF,
  parameter int DEV_BASE  = 8'hF0,
  parameter int DEV_SPAN  = 8
) (
  input  logic [7:0] port_i,
  output logic       ctrl_hit_o,
  output logic       dev_hit_o
);
  localparam int DEV_END = DEV_BASE + DEV_SPAN;

  assign ctrl_hit_o = (port_i == 8'(CTRL_PORT));
  assign dev_hit_o  = (int'(port_i) >= DEV_BASE) && (int'(port_i) < DEV_END);
endmodule

// File: rtl/mem_decode.sv
module mem_decode
  import boot_dec_pkg::*;
#(
  parameter bit RAM_64K = 1'b1,
  parameter int ADDR_W  = 16,
  parameter int SEG_AW  = 11,
  localparam int PAGE_W = ADDR_W - SEG_AW,
  localparam int ROM_AW = SEG_AW + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              boot_n_i,
  input  logic              start_n_i,
  output region_e           region_o,
  output logic [ROM_AW-1:0] rom_addr_o
);
  localparam logic [PAGE_W-1:0] MON_PAGE  = {PAGE_W{1'b1}};
  localparam logic [PAGE_W-1:0] BOOT_PAGE = MON_PAGE - PAGE_W'(2);

  logic [PAGE_W-1:0] page;
  logic mon_hit, win_hit, low_hit, rom_hit, ram_span;

  assign page    = addr_i[ADDR_W-1:SEG_AW];
  assign mon_hit = (page == MON_PAGE);
  assign win_hit = (page == BOOT_PAGE) && !boot_n_i;
  assign low_hit = (page == '0) && !boot_n_i && !start_n_i;
  assign rom_hit = mon_hit || win_hit || low_hit;

  if (RAM_64K) begin : g_ram_full
    assign ram_span = 1'b1;
  end else begin : g_ram_half
    assign ram_span = !addr_i[ADDR_W-1];
  end

  always_comb begin
    if (rom_hit)       region_o = REG_ROM;
    else if (ram_span) region_o = REG_RAM;
    else               region_o = REG_NONE;
  end

  assign rom_addr_o = {mon_hit, addr_i[SEG_AW-1:0]};
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import boot_dec_pkg::*;
#(
  parameter bit RAM_64K   = 1'b1,
  parameter int LATCH_W   = 8,
  parameter int BOOT_BIT  = 3,
  parameter int START_BIT = 5,
  parameter int CTRL_PORT = 8'hFF,
  parameter int DEV_BASE  = 8'hF0,
  parameter int DEV_SPAN  = 8,
  parameter int SEG_AW    = 11,
  localparam int IDX_W    = $clog2(LATCH_W),
  localparam int ROM_AW   = SEG_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic              io_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [IDX_W:0]    data_i,
  output logic              ram_sel_o,
  output logic              ram_we_o,
  output logic              rom_sel_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              zero_rd_o
);
  logic [LATCH_W-1:0] ctrl_q;
  logic ctrl_hit, dev_hit, ctrl_we;
  region_e region;

  io_decode #(
    .CTRL_PORT(CTRL_PORT), .DEV_BASE(DEV_BASE), .DEV_SPAN(DEV_SPAN)
  ) u_io (
    .port_i    (addr_i[7:0]),
    .ctrl_hit_o(ctrl_hit),
    .dev_hit_o (dev_hit)
  );

  assign ctrl_we = io_i && wr_i && ctrl_hit;

  // index and value arrive inverted on the data bus
  ctrl_latch #(.WIDTH(LATCH_W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (ctrl_we),
    .idx_i (~data_i[IDX_W-1:0]),
    .val_i (~data_i[IDX_W]),
    .q_o   (ctrl_q)
  );

  mem_decode #(.RAM_64K(RAM_64K), .ADDR_W(16), .SEG_AW(SEG_AW)) u_mem (
    .addr_i    (addr_i),
    .boot_n_i  (ctrl_q[BOOT_BIT]),
    .start_n_i (ctrl_q[START_BIT]),
    .region_o  (region),
    .rom_addr_o(rom_addr_o)
  );

  logic mem_cyc;
  assign mem_cyc   = !io_i && (rd_i || wr_i);
  assign ram_sel_o = mem_cyc && (region == REG_RAM);
  assign ram_we_o  = ram_sel_o && wr_i;
  assign rom_sel_o = !io_i && rd_i && (region == REG_ROM);
  assign zero_rd_o = rd_i && (io_i ? !dev_hit : (region == REG_NONE));
endmodule

// File: rtl/boot_dec_chk.sv
module boot_dec_chk #(
  parameter int LATCH_W = 8,
  parameter int SEG_AW  = 11,
  localparam int ROM_AW = SEG_AW + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [15:0]        addr_i,
  input logic               io_i,
  input logic               rd_i,
  input logic               wr_i,
  input logic               ram_sel_o,
  input logic               ram_we_o,
  input logic               rom_sel_o,
  input logic [ROM_AW-1:0]  rom_addr_o,
  input logic               zero_rd_o,
  input logic [LATCH_W-1:0] ctrl_q,
  input logic               ctrl_we
);
  logic mon_page, low_page;
  assign mon_page = (addr_i[15:SEG_AW] == '1);
  assign low_page = (addr_i[15:SEG_AW] == '0);

  p_sel_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_sel_o && rom_sel_o));
  p_rom_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_i && wr_i && mon_page) |-> !ram_we_o);
  p_monitor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_i && rd_i && mon_page) |-> (rom_sel_o && rom_addr_o[ROM_AW-1]));
  p_io_no_mem_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_i |-> (!ram_sel_o && !rom_sel_o && !ram_we_o));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> $stable(ctrl_q));
  p_one_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we |=> ($countones(ctrl_q ^ $past(ctrl_q)) <= 1));
  p_zero_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_rd_o |-> (rd_i && !ram_sel_o && !rom_sel_o));
  p_startup_mirror_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q == '0 && !io_i && rd_i && low_page) |-> rom_sel_o);
endmodule

bind boot_overlay_decoder boot_dec_chk #(.LATCH_W(LATCH_W), .SEG_AW(SEG_AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .io_i      (io_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .ram_sel_o (ram_sel_o),
  .ram_we_o  (ram_we_o),
  .rom_sel_o (rom_sel_o),
  .rom_addr_o(rom_addr_o),
  .zero_rd_o (zero_rd_o),
  .ctrl_q    (ctrl_q),
  .ctrl_we   (ctrl_we)
);

// File: tb/boot_overlay_decoder_test.sv
`timescale 1ns/1ps
module boot_overlay_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic io = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] data = '0;
  logic big_ram_sel, big_ram_we, big_rom_sel, big_zero;
  logic sm_ram_sel, sm_ram_we, sm_rom_sel, sm_zero;
  logic [11:0] big_rom_addr, sm_rom_addr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  boot_overlay_decoder #(.RAM_64K(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .io_i(io), .rd_i(rd), .wr_i(wr),
    .data_i(data), .ram_sel_o(big_ram_sel), .ram_we_o(big_ram_we),
    .rom_sel_o(big_rom_sel), .rom_addr_o(big_rom_addr), .zero_rd_o(big_zero));

  boot_overlay_decoder #(.RAM_64K(1'b0)) uut_small (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .io_i(io), .rd_i(rd), .wr_i(wr),
    .data_i(data), .ram_sel_o(sm_ram_sel), .ram_we_o(sm_ram_we),
    .rom_sel_o(sm_rom_sel), .rom_addr_o(sm_rom_addr), .zero_rd_o(sm_zero));

  // expected vector: {rom_sel, ram_sel, ram_we, zero_rd, rom_addr[11:0]}
  localparam logic [3:0] K_ROM = 4'b1000, K_RAM = 4'b0100, K_RAMW = 4'b0110,
                         K_ZERO = 4'b0001, K_NONE = 4'b0000;

  function automatic logic [15:0] exp_v(logic [3:0] k, logic [15:0] a);
    return {k, (a[15:11] == 5'h1F), a[10:0]};
  endfunction

  task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic i, logic r, logic w, logic [15:0] a,
                     logic [3:0] kb, logic [3:0] ks, string tag);
    @(negedge clk);
    io = i; rd = r; wr = w; addr = a;
    #1;
    cmp({tag, " big"}, {big_rom_sel, big_ram_sel, big_ram_we, big_zero, big_rom_addr},
        exp_v(kb, a));
    cmp({tag, " small"}, {sm_rom_sel, sm_ram_sel, sm_ram_we, sm_zero, sm_rom_addr},
        exp_v(ks, a));
    @(negedge clk);
    rd = 1'b0; wr = 1'b0; io = 1'b0;
  endtask

  task automatic io_wr(logic [7:0] port, logic [3:0] d);
    @(negedge clk);
    io = 1'b1; wr = 1'b1; addr = {8'h00, port}; data = d;
    @(negedge clk);
    io = 1'b0; wr = 1'b0; data = '0;
  endtask

  task automatic t_reset;
    cyc(0, 1, 0, 16'h0000, K_ROM, K_ROM, "R1 reset read 0000");
    cyc(0, 1, 0, 16'h0123, K_ROM, K_ROM, "R4 low mirror 0123");
    cyc(0, 1, 0, 16'h07FF, K_ROM, K_ROM, "R4 low mirror top");
    cyc(0, 1, 0, 16'hE800, K_ROM, K_ROM, "R4 window E800");
    cyc(0, 1, 0, 16'h0800, K_RAM, K_RAM, "R7 above mirror");
    cyc(0, 1, 0, 16'hF800, K_ROM, K_ROM, "R6 monitor F800");
  endtask

  task automatic t_rom_write;
    cyc(0, 0, 1, 16'h0010, K_NONE, K_NONE, "R9 write to low mirror");
    cyc(0, 0, 1, 16'hF900, K_NONE, K_NONE, "R9 write to monitor");
    cyc(0, 0, 1, 16'h4000, K_RAMW, K_RAMW, "R10 ram write");
  endtask

  task automatic t_ignored_writes;
    io_wr(8'hF4, 4'h2);
    cyc(0, 1, 0, 16'h0000, K_ROM, K_ROM, "R2 other port ignored");
    io_wr(8'hFF, 4'h7);
    cyc(0, 1, 0, 16'h0000, K_ROM, K_ROM, "R2 bit0 write no map change");
    cyc(0, 1, 0, 16'hE900, K_ROM, K_ROM, "R2 bit0 window kept");
  endtask

  task automatic t_leave_startup;
    io_wr(8'hFF, 4'h2);
    cyc(0, 1, 0, 16'h0000, K_RAM, K_RAM, "R5 low back to ram");
    cyc(0, 1, 0, 16'hE810, K_ROM, K_ROM, "R5 window kept");
    cyc(0, 1, 0, 16'hF7FF, K_RAM, K_ZERO, "R7 F7FF per size");
    cyc(0, 1, 0, 16'h9000, K_RAM, K_ZERO, "R8 small upper unmapped");
  endtask

  task automatic t_disable;
    io_wr(8'hFF, 4'h4);
    cyc(0, 1, 0, 16'hE800, K_RAM, K_ZERO, "R3 window off");
    cyc(0, 1, 0, 16'h0000, K_RAM, K_RAM, "R3 low ram");
    cyc(0, 1, 0, 16'hFFFF, K_ROM, K_ROM, "R6 monitor kept");
    io_wr(8'hFF, 4'hC);
    cyc(0, 1, 0, 16'hE800, K_ROM, K_ROM, "R2 re-enable window");
    cyc(0, 1, 0, 16'h0000, K_RAM, K_RAM, "R5 start still set");
    io_wr(8'hFF, 4'hA);
    cyc(0, 1, 0, 16'h0000, K_ROM, K_ROM, "R4 start cleared again");
    io_wr(8'hFF, 4'h4);
    cyc(0, 1, 0, 16'h0400, K_RAM, K_RAM, "R3 off beats start-up");
  endtask

  task automatic t_io;
    cyc(1, 1, 0, 16'h00F4, K_NONE, K_NONE, "R8 device port read");
    cyc(1, 1, 0, 16'h00FF, K_ZERO, K_ZERO, "R8 control port read");
    cyc(1, 1, 0, 16'h0020, K_ZERO, K_ZERO, "R8 empty port read");
    cyc(1, 0, 1, 16'h4020, K_NONE, K_NONE, "R10 io write no mem");
    cyc(1, 1, 0, 16'hF800, K_ZERO, K_ZERO, "R10 io read no rom");
  endtask

  task automatic t_timing;
    io_wr(8'hFF, 4'hC);
    @(negedge clk);
    io = 1'b1; wr = 1'b1; addr = 16'h00FF; data = 4'h4;
    #1;
    io = 1'b0; wr = 1'b0; rd = 1'b1; addr = 16'hE800;
    #0.5;
    cmp("R2 before edge", {big_rom_sel, big_ram_sel}, 16'b10);
    io = 1'b1; wr = 1'b1; rd = 1'b0; addr = 16'h00FF;
    @(negedge clk);
    io = 1'b0; wr = 1'b0; rd = 1'b1; addr = 16'hE800;
    #1;
    cmp("R2 after edge", {big_rom_sel, big_ram_sel}, 16'b01);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic t_mid_reset;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd = 1'b1; addr = 16'h0000;
    #0.5;
    cmp("R1 reset asserted", {big_rom_sel, big_ram_sel, sm_rom_sel, sm_ram_sel}, 16'b1010);
    rd = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 1, 0, 16'h0200, K_ROM, K_ROM, "R1 after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rom_write();
    t_ignored_writes();
    t_leave_startup();
    t_disable();
    t_io();
    t_timing();
    t_mid_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule